// File: doc/BRIEF.md
# Signed multiply-accumulate long unit

This execution unit takes one 32-bit instruction word together with the values of the four registers it names. It multiplies two signed 32-bit operands, adds the signed 64-bit accumulator formed from a high word and a low word, and returns the wrapped 64-bit sum as two 32-bit words. The destination indices and the write enables for the register file come with the result. The unit can also return negative and zero flags, and it reports a status code.

Two encodings are recognised. The first is a conditional form, which carries a condition field and a flag-setting bit. The second is a compact two-halfword form, which never sets flags. The caller evaluates the condition and passes the outcome on `cond_pass`. A squashed operation still travels down the pipeline, but all of its write enables are low. An operand or destination index of 15 is reported as illegal. Equal high and low destination indices are resolved to one outcome, chosen by the `ALIAS_MODE` parameter.

The pipeline has three stages and a fixed latency, and it accepts one operation on every cycle. The latency never depends on operand values, on the incoming flags or on the decoded outcome.

Top module: `mac_long_unit`

## Requirements
- R1: For a legal operation, the 64-bit result is (signed rn × signed rm) + signed {hi_val, lo_val}, wrapped modulo 2^64. `res_hi` carries bits 63:32 of the result and `res_lo` carries bits 31:0. `wr_hi` and `wr_lo` are both 1 and always equal each other.
- R2: Conditional form: `insn[31:28]` ≠ 4'hF, `insn[27:21]` = 7'b0000111 and `insn[7:4]` = 4'b1001. In this form, bit 20 enables flag setting, [19:16] is the high destination, [15:12] is the low destination, [11:8] is rm and [3:0] is rn.
- R3: When flags are written (`flags_we` = 1), `flags_out` is {N, Z, C, V}. N is bit 63 of the result. Z is 1 only when all 64 result bits are zero. C and V are copied unchanged from `cv_in` = {C, V}.
- R4: Compact form: `insn[31:20]` = 12'hFBC and `insn[7:4]` = 4'b0000. In this form, [19:16] is rn, [15:12] is the low destination, [11:8] is the high destination and [3:0] is rm. `flags_we` is never set for this form.
- R5: A word that matches neither form yields status 2'b01 (undefined) with all write enables low.
- R6: For a word that matches either form, any of the four indices equal to 15 yields status 2'b10 with all write enables low. This takes precedence over R7.
- R7: When the high and low destination indices are equal, the outcome depends on `ALIAS_MODE`:
  - 0 gives status 2'b01 with no writes.
  - 1 gives status 2'b11 with no writes.
  - 2 gives status 2'b11 and writes the normal R1 sum, and the flags as in R3 for the conditional form, to that one index.
- R8: With `cond_pass` low, the status is reported as for a passed operation, but `wr_hi`, `wr_lo` and `flags_we` are all low.
- R9: An operation accepted (`in_valid` and `in_ready` both high) at clock edge k appears with `out_valid` high after edge k+2, whatever its data or outcome. `in_ready` is high from the first edge after reset onwards, so issue can continue on every cycle.
- R10: While `rst_n` is low, `out_valid`, `in_ready` and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| insn | input | 32 | Instruction word |
| rn_val | input | 32 | Value of the multiplicand register |
| rm_val | input | 32 | Value of the multiplier register |
| lo_val | input | 32 | Value of the low accumulator register |
| hi_val | input | 32 | Value of the high accumulator register |
| cv_in | input | 2 | Current {C, V} flags |
| cond_pass | input | 1 | Condition check passed |
| out_valid | output | 1 | Result present |
| res_hi | output | 32 | Upper result word |
| res_lo | output | 32 | Lower result word |
| dst_hi | output | 4 | High destination index |
| dst_lo | output | 4 | Low destination index |
| wr_hi | output | 1 | Write enable for high destination |
| wr_lo | output | 1 | Write enable for low destination |
| flags_out | output | 4 | {N, Z, C, V} |
| flags_we | output | 1 | Flag write enable |
| status | output | 2 | 00 ok, 01 undefined, 10 index 15, 11 aliased |

## Verification
The bench instantiates the unit three times, once for each value of `ALIAS_MODE` (0, 1 and 2). All three copies receive the same stimulus stream. The aliased-destination case therefore shows all three outcomes side by side in the same cycle. The same stream also confirms that the parameter has no effect on legal, squashed or malformed operations.

// File: rtl/mac_long_unit.sv
module mac_long_unit #(
  parameter int ALIAS_MODE = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] insn,
  input  logic [31:0] rn_val,
  input  logic [31:0] rm_val,
  input  logic [31:0] lo_val,
  input  logic [31:0] hi_val,
  input  logic [1:0]  cv_in,
  input  logic        cond_pass,
  output logic        out_valid,
  output logic [31:0] res_hi,
  output logic [31:0] res_lo,
  output logic [3:0]  dst_hi,
  output logic [3:0]  dst_lo,
  output logic        wr_hi,
  output logic        wr_lo,
  output logic [3:0]  flags_out,
  output logic        flags_we,
  output logic [1:0]  status
);
  localparam logic [1:0] ST_OK    = 2'b00;
  localparam logic [1:0] ST_UNDEF = 2'b01;
  localparam logic [1:0] ST_IDX15 = 2'b10;
  localparam logic [1:0] ST_ALIAS = 2'b11;

  logic take, is_cond, is_cmp, bad15, same_dst, commit;
  logic [3:0] f_rn, f_rm, f_hi, f_lo;
  logic [1:0] st_d;

  assign take    = in_valid & in_ready;
  assign is_cond = (insn[31:28] != 4'hF) && (insn[27:21] == 7'b0000111) && (insn[7:4] == 4'b1001);
  assign is_cmp  = (insn[31:20] == 12'hFBC) && (insn[7:4] == 4'b0000);

  assign f_rn = is_cmp ? insn[19:16] : insn[3:0];
  assign f_rm = is_cmp ? insn[3:0]   : insn[11:8];
  assign f_hi = is_cmp ? insn[11:8]  : insn[19:16];
  assign f_lo = insn[15:12];

  assign bad15    = (&f_rn) | (&f_rm) | (&f_hi) | (&f_lo);
  assign same_dst = (f_hi == f_lo);

  always_comb begin
    st_d   = ST_OK;
    commit = 1'b1;
    if (!(is_cond || is_cmp)) begin
      st_d   = ST_UNDEF;
      commit = 1'b0;
    end else if (bad15) begin
      st_d   = ST_IDX15;
      commit = 1'b0;
    end else if (same_dst) begin
      case (ALIAS_MODE)
        0:       begin st_d = ST_UNDEF; commit = 1'b0; end
        1:       begin st_d = ST_ALIAS; commit = 1'b0; end
        default: begin st_d = ST_ALIAS; commit = 1'b1; end
      endcase
    end
  end

  // stage 1: captured operands and decode
  logic        v1, we1, fs1;
  logic [31:0] a1, b1;
  logic [63:0] acc1;
  logic [1:0]  cv1, st1;
  logic [3:0]  dh1, dl1;
  // stage 2: product
  logic        v2, we2, fs2;
  logic [63:0] prod2, acc2;
  logic [1:0]  cv2, st2;
  logic [3:0]  dh2, dl2;

  logic [63:0] sum;
  assign sum = prod2 + acc2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      wr_hi     <= 1'b0;
      wr_lo     <= 1'b0;
      flags_we  <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      v1        <= take;
      v2        <= v1;
      out_valid <= v2;
      wr_hi     <= v2 & we2;
      wr_lo     <= v2 & we2;
      flags_we  <= v2 & fs2;
    end
  end

  always_ff @(posedge clk) begin
    a1    <= rn_val;
    b1    <= rm_val;
    acc1  <= {hi_val, lo_val};
    cv1   <= cv_in;
    st1   <= st_d;
    dh1   <= f_hi;
    dl1   <= f_lo;
    we1   <= commit & cond_pass;
    fs1   <= commit & cond_pass & is_cond & insn[20];

    prod2 <= {{32{a1[31]}}, a1} * {{32{b1[31]}}, b1};
    acc2  <= acc1;
    cv2   <= cv1;
    st2   <= st1;
    dh2   <= dh1;
    dl2   <= dl1;
    we2   <= we1;
    fs2   <= fs1;

    res_hi    <= sum[63:32];
    res_lo    <= sum[31:0];
    dst_hi    <= dh2;
    dst_lo    <= dl2;
    status    <= st2;
    flags_out <= {sum[63], (sum == 64'd0), cv2};
  end
endmodule

// File: rtl/mac_long_unit_chk.sv
module mac_long_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  cv_in,
  input logic        out_valid,
  input logic [31:0] res_hi,
  input logic [31:0] res_lo,
  input logic        wr_hi,
  input logic        wr_lo,
  input logic [3:0]  flags_out,
  input logic        flags_we,
  input logic [1:0]  status
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid && in_ready, 3))); // R9
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> in_ready); // R9
  AST_CV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && flags_we) |-> (flags_out[1:0] == $past(cv_in, 3))); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags_we) |-> (flags_out[2] == (res_hi == 32'd0 && res_lo == 32'd0))); // R3
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags_we) |-> (flags_out[3] == res_hi[31])); // R3
  AST_PAIRED_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi == wr_lo); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_hi && !flags_we)); // R8
  AST_NO_WRITE_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (status == 2'b01 || status == 2'b10)) |-> (!wr_hi && !flags_we)); // R5 R6
  AST_FLAGS_NEED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> wr_hi); // R8
endmodule

bind mac_long_unit mac_long_unit_chk chk (.*);

// File: tb/mac_long_unit_test.sv
module mac_long_unit_test;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct {
    bit         v;
    bit         we;
    bit         fwe;
    logic [1:0] st;
    logic [31:0] hi, lo;
    logic [3:0] dh, dl, fl;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, cond_pass = 1'b0;
  logic [31:0] insn = '0, rn_val = '0, rm_val = '0, lo_val = '0, hi_val = '0;
  logic [1:0] cv_in = '0;
  string cur_tag = "";

  logic        o_rdy[3], o_v[3], o_wh[3], o_wl[3], o_fwe[3];
  logic [31:0] o_hi[3], o_lo[3];
  logic [3:0]  o_dh[3], o_dl[3], o_fl[3];
  logic [1:0]  o_st[3];

  int checks = 0, failures = 0;
  bit rdy_model = 1'b0;
  exp_t q0[$], q1[$], q2[$];

  always #4 clk = ~clk;

  mac_long_unit #(.ALIAS_MODE(0)) uut (.clk, .rst_n, .in_valid, .in_ready(o_rdy[0]), .insn,
    .rn_val, .rm_val, .lo_val, .hi_val, .cv_in, .cond_pass, .out_valid(o_v[0]),
    .res_hi(o_hi[0]), .res_lo(o_lo[0]), .dst_hi(o_dh[0]), .dst_lo(o_dl[0]), .wr_hi(o_wh[0]),
    .wr_lo(o_wl[0]), .flags_out(o_fl[0]), .flags_we(o_fwe[0]), .status(o_st[0]));
  mac_long_unit #(.ALIAS_MODE(1)) uut_nop (.clk, .rst_n, .in_valid, .in_ready(o_rdy[1]), .insn,
    .rn_val, .rm_val, .lo_val, .hi_val, .cv_in, .cond_pass, .out_valid(o_v[1]),
    .res_hi(o_hi[1]), .res_lo(o_lo[1]), .dst_hi(o_dh[1]), .dst_lo(o_dl[1]), .wr_hi(o_wh[1]),
    .wr_lo(o_wl[1]), .flags_out(o_fl[1]), .flags_we(o_fwe[1]), .status(o_st[1]));
  mac_long_unit #(.ALIAS_MODE(2)) uut_unk (.clk, .rst_n, .in_valid, .in_ready(o_rdy[2]), .insn,
    .rn_val, .rm_val, .lo_val, .hi_val, .cv_in, .cond_pass, .out_valid(o_v[2]),
    .res_hi(o_hi[2]), .res_lo(o_lo[2]), .dst_hi(o_dh[2]), .dst_lo(o_dl[2]), .wr_hi(o_wh[2]),
    .wr_lo(o_wl[2]), .flags_out(o_fl[2]), .flags_we(o_fwe[2]), .status(o_st[2]));

  function automatic exp_t model(int mode);
    exp_t e;
    bit isa, ist, commit;
    logic [3:0] n, m, h, l;
    longint sum;
    isa = insn[31:28] != 4'hF && insn[27:21] == 7'b0000111 && insn[7:4] == 4'b1001;
    ist = insn[31:20] == 12'hFBC && insn[7:4] == 4'b0000;
    if (ist) begin n = insn[19:16]; l = insn[15:12]; h = insn[11:8]; m = insn[3:0]; end
    else     begin h = insn[19:16]; l = insn[15:12]; m = insn[11:8]; n = insn[3:0]; end
    sum = longint'(signed'(rn_val)) * longint'(signed'(rm_val)) + longint'({hi_val, lo_val});
    e.v = in_valid && rdy_model;
    e.tag = cur_tag;
    commit = 1'b1;
    e.st = 2'b00;
    if (!(isa || ist)) begin e.st = 2'b01; commit = 0; end
    else if (n == 15 || m == 15 || h == 15 || l == 15) begin e.st = 2'b10; commit = 0; end
    else if (h == l) begin
      e.st = (mode == 0) ? 2'b01 : 2'b11;
      commit = (mode == 2);
    end
    e.we = commit && cond_pass;
    e.fwe = e.we && isa && insn[20];
    e.hi = sum[63:32];
    e.lo = sum[31:0];
    e.dh = h;
    e.dl = l;
    e.fl = {sum[63], sum == 0, cv_in};
    return e;
  endfunction

  task automatic fail_line(int k, string what, string tag, logic [63:0] act, logic [63:0] exp);
    failures++;
    $display("FAIL %s inst%0d %s actual=%h expected=%h", tag, k, what, act, exp);
  endtask

  task automatic compare(int k, exp_t e);
    checks++;
    if (o_v[k] !== e.v) begin fail_line(k, "out_valid", e.tag, 64'(o_v[k]), 64'(e.v)); return; end
    if (!e.v) return;
    if (o_st[k] !== e.st) fail_line(k, "status", e.tag, 64'(o_st[k]), 64'(e.st));
    if (o_wh[k] !== e.we || o_wl[k] !== e.we)
      fail_line(k, "write enables", e.tag, 64'({o_wh[k], o_wl[k]}), 64'({e.we, e.we}));
    if (o_fwe[k] !== e.fwe) fail_line(k, "flags_we", e.tag, 64'(o_fwe[k]), 64'(e.fwe));
    if (e.we && {o_hi[k], o_lo[k]} !== {e.hi, e.lo})
      fail_line(k, "result", e.tag, {o_hi[k], o_lo[k]}, {e.hi, e.lo});
    if (e.we && {o_dh[k], o_dl[k]} !== {e.dh, e.dl})
      fail_line(k, "dest", e.tag, 64'({o_dh[k], o_dl[k]}), 64'({e.dh, e.dl}));
    if (e.fwe && o_fl[k] !== e.fl) fail_line(k, "flags", e.tag, 64'(o_fl[k]), 64'(e.fl));
  endtask

  task automatic step();
    @(posedge clk);
    q0.push_back(model(0));
    q1.push_back(model(1));
    q2.push_back(model(2));
    if (rst_n) rdy_model = 1'b1;
    @(negedge clk);
    if (q0.size() == 3) begin
      compare(0, q0.pop_front());
      compare(1, q1.pop_front());
      compare(2, q2.pop_front());
    end
  endtask

  function automatic logic [31:0] enc_c(logic [3:0] c, bit s, logic [3:0] h, l, m, n);
    return {c, 7'b0000111, s, h, l, m, 4'b1001, n};
  endfunction
  function automatic logic [31:0] enc_t(logic [3:0] n, l, h, m);
    return {12'hFBC, n, l, h, 4'b0000, m};
  endfunction

  task automatic op(string tag, logic [31:0] w, logic [31:0] a, b, l, h, logic [1:0] cv, bit cp);
    cur_tag = tag; insn = w; rn_val = a; rm_val = b; lo_val = l; hi_val = h;
    cv_in = cv; cond_pass = cp; in_valid = 1'b1;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; cur_tag = "R9";
      step();
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (o_v[k] !== 1'b0 || o_rdy[k] !== 1'b0 || o_wh[k] !== 1'b0 || o_fwe[k] !== 1'b0)
        fail_line(k, "reset state", "R10", 64'({o_v[k], o_rdy[k], o_wh[k], o_fwe[k]}), 64'd0);
    end
    rst_n = 1'b1;
    idle(2);
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (o_rdy[k] !== 1'b1) fail_line(k, "in_ready", "R9", 64'(o_rdy[k]), 64'd1);
    end

    op("R1", enc_c(4'h0, 1, 4'd2, 4'd1, 4'd3, 4'd4), 32'd3, 32'd5, 32'd0, 32'd0, 2'b10, 1);
    op("R3", enc_c(4'hE, 1, 4'd5, 4'd6, 4'd7, 4'd8), -32'sd7, 32'd9, 32'd100, 32'd0, 2'b01, 1);
    op("R3", enc_c(4'h1, 1, 4'd0, 4'd1, 4'd2, 4'd3), 32'hFFFFFFFE, 32'd3, 32'd6, 32'd0, 2'b11, 1);
    op("R1", enc_c(4'h2, 1, 4'd9, 4'd8, 4'd7, 4'd6), 32'h80000000, 32'h80000000,
       32'hFFFFFFFF, 32'h7FFFFFFF, 2'b00, 1);
    op("R2", enc_c(4'h3, 0, 4'd4, 4'd12, 4'd1, 4'd0), 32'h12345678, 32'h9ABCDEF0,
       32'h0F0F0F0F, 32'hF0F0F0F0, 2'b10, 1);
    op("R4", enc_t(4'd1, 4'd2, 4'd3, 4'd4), 32'hFFFF0000, 32'h00010000, 32'd1, 32'd0, 2'b11, 1);
    op("R4", enc_t(4'd13, 4'd0, 4'd14, 4'd12), -32'sd1, -32'sd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b01, 1);
    op("R8", enc_c(4'h0, 1, 4'd2, 4'd1, 4'd3, 4'd4), 32'd3, 32'd5, 32'd0, 32'd0, 2'b10, 0);
    op("R8", enc_c(4'h0, 1, 4'd2, 4'd2, 4'd3, 4'd4), 32'd3, 32'd5, 32'd0, 32'd0, 2'b10, 0);
    op("R5", 32'hDEADBEEF, 32'd1, 32'd1, 32'd1, 32'd1, 2'b00, 1);
    op("R5", enc_c(4'hF, 1, 4'd2, 4'd1, 4'd3, 4'd4), 32'd1, 32'd1, 32'd1, 32'd1, 2'b00, 1);
    op("R5", enc_t(4'd1, 4'd2, 4'd3, 4'd4) | 32'h10, 32'd1, 32'd1, 32'd1, 32'd1, 2'b00, 1);
    op("R6", enc_c(4'h0, 1, 4'd2, 4'd1, 4'd3, 4'd15), 32'd1, 32'd1, 32'd1, 32'd1, 2'b00, 1);
    op("R6", enc_t(4'd1, 4'd2, 4'd3, 4'd15), 32'd1, 32'd1, 32'd1, 32'd1, 2'b00, 1);
    op("R6", enc_c(4'h0, 1, 4'd15, 4'd15, 4'd3, 4'd4), 32'd1, 32'd1, 32'd1, 32'd1, 2'b00, 1);
    op("R7", enc_c(4'h0, 1, 4'd5, 4'd5, 4'd3, 4'd4), 32'd10, 32'd10, 32'd5, 32'd0, 2'b01, 1);
    op("R7", enc_t(4'd1, 4'd6, 4'd6, 4'd2), -32'sd4, 32'd1, 32'd4, 32'd0, 2'b10, 1);
    idle(2);
    op("R9", enc_c(4'h0, 1, 4'd2, 4'd1, 4'd3, 4'd4), 32'd0, 32'd0, 32'd0, 32'd0, 2'b11, 1);
    idle(1);
    for (int i = 0; i < 60; i++) begin
      logic [3:0] h, l;
      h = 4'($urandom_range(0, 14));
      l = 4'((h + 4'($urandom_range(1, 13))) % 15);
      if (i % 2 == 0)
        op("R1", enc_c(4'($urandom_range(0, 14)), 1'($urandom), h, l, 4'($urandom_range(0, 14)),
           4'($urandom_range(0, 14))), $urandom, $urandom, $urandom, $urandom, 2'($urandom), 1);
      else
        op("R4", enc_t(4'($urandom_range(0, 14)), l, h, 4'($urandom_range(0, 14))),
           $urandom, $urandom, $urandom, $urandom, 2'($urandom), 1'($urandom));
    end
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule